// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Control Registers

This block is the register front end of one bus-master disk DMA channel. Software reaches it over a small 32-bit register bus with per-byte write enables. It keeps three pieces of state: a command byte that starts or stops the channel and picks the transfer direction, a status byte, and a 32-bit bus address for the descriptor table. The data mover fetches descriptors from that address and moves the data. It reports back through three pulses: end of table, error, and device interrupt.

The status byte holds four kinds of bit. The active flag is read-only and is owned by the hardware. The error and interrupt flags are sticky and are cleared by writing one. The two per-drive DMA-capable flags are plain storage. The block drives a run signal and a direction signal to the data mover and an interrupt line to the host. It also flags the single status pattern that marks a transfer as finished cleanly.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the command byte, status byte and table pointer all read 0, and xferRun, xferToMem, irqOut and xferOk are low.
- R2: The command byte sits in byte lane 0 of the word at offset 0. Bit 0 is the go bit and bit 3 is the direction bit, where 1 means device to memory; xferToMem shows bit 3. The other command bits read 0.
- R3: Writing the go bit as 1 while it is 0 sets the active flag (status bit 0) on the next edge, and xferRun follows it. Writing go as 1 while it is already 1 does not set the active flag again.
- R4: Writing the go bit as 0 clears the active flag on the next edge.
- R5: An engDone pulse clears the active flag but leaves the go bit as written. If a re-arm and engDone fall in the same cycle, the re-arm wins.
- R6: engErr sets status bit 1 and devIrq sets status bit 2. irqOut is high exactly while status bit 2 is set.
- R7: Status bits 1 and 2 clear when a 1 is written to them. Writing 0 leaves them unchanged. A set pulse in the same cycle as a clearing write wins.
- R8: Writes to status bit 0 are ignored.
- R9: Status bits 5 and 6 are read/write DMA-capable flags for drive 0 and drive 1. Status bits 3, 4 and 7 read 0.
- R10: The 32-bit table pointer is the word at offset 4. It reads back as written and drives tablePtr.
- R11: xferOk is high exactly when status bits [2:0] equal binary 100: interrupt set, no error, not active.
- R12: A write changes only the byte lanes whose byteEn bit is set. The status byte is lane 2 of the word at offset 0. Address bit 2 selects the word, and address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register byte address; bit 2 selects the word |
| wrEn | input | 1 | Write strobe, one cycle per write |
| byteEn | input | DATA_W/8 | Byte lane enables for a write |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for the word at regAddr, combinational |
| engDone | input | 1 | Data mover reached end of table |
| engErr | input | 1 | Data mover saw a bus error |
| devIrq | input | 1 | Device raised its interrupt |
| xferRun | output | 1 | Active flag: the data mover may run |
| xferToMem | output | 1 | Direction: 1 means device to memory |
| irqOut | output | 1 | Interrupt to the host |
| xferOk | output | 1 | Status shows a cleanly finished transfer |
| tablePtr | output | DATA_W | Descriptor table bus address |

## Verification
A wrong active flag shows up on xferRun and in status bit 0 on the first edge after the arming write, the stop write or the engDone pulse. A lost sticky flag shows up on irqOut or in a status read in the cycle after the pulse. The hard cases are same-cycle collisions: a set pulse against a clearing write, and a re-arm against end of table. In both, the wrong priority shows at the ports one cycle later and stays visible until software touches the register again. A byte-lane decode error damages neighbouring bytes, and a read of the affected word shows it at once.

// File: rtl/dma_chan_regs_pkg.sv
package dma_chan_regs_pkg;
  // command byte bit positions (software decodes these)
  localparam int CMD_GO    = 0;
  localparam int CMD_TOMEM = 3;
  // status byte bit positions
  localparam int ST_ACT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_IRQ  = 2;
  localparam int ST_CAP0 = 5;
  localparam int ST_CAP1 = 6;
  // byte lane of the control word that carries the status byte
  localparam int STAT_LANE = 2;

  typedef struct packed {
    logic cmdWr;   // command byte written
    logic statWr;  // status byte written
    logic arm;     // go bit rises
    logic halt;    // go bit written as zero
  } ctlStrobe_t;
endpackage

// File: rtl/dma_chan_regs_ctrl.sv
module dma_chan_regs_ctrl
  import dma_chan_regs_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int LANES  = 4
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [LANES-1:0]  byteEn,
  input  logic              goData,
  input  logic              goNow,
  output ctlStrobe_t        strobe,
  output logic [LANES-1:0]  ptrLaneWr
);
  localparam int WORD_BIT = $clog2(LANES);

  logic ctlWord;
  logic ptrWord;

  assign ctlWord = wrEn && (regAddr[WORD_BIT] == 1'b0);
  assign ptrWord = wrEn && (regAddr[WORD_BIT] == 1'b1);

  always_comb begin
    strobe.cmdWr  = ctlWord && byteEn[0];
    strobe.statWr = ctlWord && byteEn[STAT_LANE];
    strobe.arm    = strobe.cmdWr && goData && !goNow;
    strobe.halt   = strobe.cmdWr && !goData;
  end

  assign ptrLaneWr = ptrWord ? byteEn : '0;
endmodule

// File: rtl/dma_chan_regs_dp.sv
module dma_chan_regs_dp
  import dma_chan_regs_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [DATA_W/8-1:0] ptrLaneWr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                engDone,
  input  logic                engErr,
  input  logic                devIrq,
  output logic                goNow,
  output logic [DATA_W-1:0]   rdData,
  output logic                actFlag,
  output logic                toMem,
  output logic                irqFlag,
  output logic                okFlag,
  output logic [DATA_W-1:0]   ptrOut
);
  localparam int LANES    = DATA_W / 8;
  localparam int WORD_BIT = $clog2(LANES);
  localparam int SB       = 8 * STAT_LANE;

  logic       goQ, toMemQ, actQ, errQ, irqQ;
  logic [1:0] capQ;
  logic [DATA_W-1:0] ptrQ;
  logic [7:0] cmdByte, statByte;

  // command byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goQ    <= 1'b0;
      toMemQ <= 1'b0;
    end else if (strobe.cmdWr) begin
      goQ    <= wrData[CMD_GO];
      toMemQ <= wrData[CMD_TOMEM];
    end
  end

  // active flag: arming beats end of table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        actQ <= 1'b0;
    else if (strobe.arm)              actQ <= 1'b1;
    else if (strobe.halt || engDone)  actQ <= 1'b0;
  end

  // sticky flags: a set pulse beats a clearing write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ <= 1'b0;
      irqQ <= 1'b0;
    end else begin
      if (engErr)                                 errQ <= 1'b1;
      else if (strobe.statWr && wrData[SB+ST_ERR]) errQ <= 1'b0;
      if (devIrq)                                 irqQ <= 1'b1;
      else if (strobe.statWr && wrData[SB+ST_IRQ]) irqQ <= 1'b0;
    end
  end

  // per-drive capability flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              capQ <= 2'b00;
    else if (strobe.statWr) capQ <= {wrData[SB+ST_CAP1], wrData[SB+ST_CAP0]};
  end

  // descriptor table pointer, one register per byte lane
  for (genvar ln = 0; ln < LANES; ln++) begin : g_ptrLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              ptrQ[8*ln +: 8] <= 8'h00;
      else if (ptrLaneWr[ln]) ptrQ[8*ln +: 8] <= wrData[8*ln +: 8];
    end
  end

  always_comb begin
    cmdByte            = 8'h00;
    cmdByte[CMD_GO]    = goQ;
    cmdByte[CMD_TOMEM] = toMemQ;
    statByte           = 8'h00;
    statByte[ST_ACT]   = actQ;
    statByte[ST_ERR]   = errQ;
    statByte[ST_IRQ]   = irqQ;
    statByte[ST_CAP0]  = capQ[0];
    statByte[ST_CAP1]  = capQ[1];
  end

  always_comb begin
    rdData = '0;
    if (regAddr[WORD_BIT]) begin
      rdData = ptrQ;
    end else begin
      rdData[7:0]     = cmdByte;
      rdData[SB +: 8] = statByte;
    end
  end

  assign goNow   = goQ;
  assign actFlag = actQ;
  assign toMem   = toMemQ;
  assign irqFlag = irqQ;
  assign okFlag  = (statByte[2:0] == 3'b100);
  assign ptrOut  = ptrQ;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_regs_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                wrEn,
  input  logic [DATA_W/8-1:0] byteEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic                engDone,
  input  logic                engErr,
  input  logic                devIrq,
  output logic                xferRun,
  output logic                xferToMem,
  output logic                irqOut,
  output logic                xferOk,
  output logic [DATA_W-1:0]   tablePtr
);
  localparam int LANES = DATA_W / 8;

  ctlStrobe_t       strobe;
  logic [LANES-1:0] ptrLaneWr;
  logic             goNow;

  dma_chan_regs_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .wrEn      (wrEn),
    .regAddr   (regAddr),
    .byteEn    (byteEn),
    .goData    (wrData[CMD_GO]),
    .goNow     (goNow),
    .strobe    (strobe),
    .ptrLaneWr (ptrLaneWr)
  );

  dma_chan_regs_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .ptrLaneWr (ptrLaneWr),
    .wrData    (wrData),
    .regAddr   (regAddr),
    .engDone   (engDone),
    .engErr    (engErr),
    .devIrq    (devIrq),
    .goNow     (goNow),
    .rdData    (rdData),
    .actFlag   (xferRun),
    .toMem     (xferToMem),
    .irqFlag   (irqOut),
    .okFlag    (xferOk),
    .ptrOut    (tablePtr)
  );
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                wrEn,
  input logic [DATA_W/8-1:0] byteEn,
  input logic [DATA_W-1:0]   wrData,
  input logic                engDone,
  input logic                devIrq,
  input logic                xferRun,
  input logic                irqOut,
  input logic                xferOk
);
  logic cmdWrite, statWrite;
  assign cmdWrite  = wrEn && !regAddr[2] && byteEn[0];
  assign statWrite = wrEn && !regAddr[2] && byteEn[2];

  AST_RUN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferRun) |-> $past(cmdWrite && wrData[0])); // R3
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && !wrData[0]) |=> !xferRun); // R4
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (engDone && !cmdWrite) |=> !xferRun); // R5
  AST_IRQ_SETS: assert property (@(posedge clk) disable iff (!rstN)
    devIrq |=> irqOut); // R6
  AST_IRQ_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(statWrite && wrData[18])); // R7
  AST_OK_PATTERN: assert property (@(posedge clk) disable iff (!rstN)
    xferOk |-> (irqOut && !xferRun)); // R11
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .byteEn(byteEn),
  .wrData(wrData), .engDone(engDone), .devIrq(devIrq), .xferRun(xferRun),
  .irqOut(irqOut), .xferOk(xferOk)
);

// File: tb/dma_chan_regs_test.sv
`timescale 1ns/1ps
module dma_chan_regs_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  byteEn = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        engDone = 1'b0, engErr = 1'b0, devIrq = 1'b0;
  logic        xferRun, xferToMem, irqOut, xferOk;
  logic [31:0] tablePtr;

  int total = 0;
  int bad = 0;

  // reference state
  logic mGo = 0, mDir = 0, mAct = 0, mErr = 0, mIrq = 0;
  logic [1:0]  mCap = 0;
  logic [31:0] mPtr = 0;

  always #2.5 clk = ~clk;

  dma_chan_regs uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .byteEn(byteEn),
    .wrData(wrData), .rdData(rdData), .engDone(engDone), .engErr(engErr),
    .devIrq(devIrq), .xferRun(xferRun), .xferToMem(xferToMem), .irqOut(irqOut),
    .xferOk(xferOk), .tablePtr(tablePtr)
  );

  function automatic logic [31:0] expWord(input logic sel);
    logic [31:0] w;
    if (sel) return mPtr;
    w = '0;
    w[0] = mGo; w[3] = mDir;
    w[16] = mAct; w[17] = mErr; w[18] = mIrq; w[21] = mCap[0]; w[22] = mCap[1];
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkOutputs();
    check("R3 R4 R5 run", 32'(xferRun), 32'(mAct));
    check("R2 dir", 32'(xferToMem), 32'(mDir));
    check("R6 irq", 32'(irqOut), 32'(mIrq));
    check("R11 ok", 32'(xferOk), 32'({mIrq, mErr, mAct} == 3'b100));
    check("R10 ptr", tablePtr, mPtr);
  endtask

  // one clock of stimulus, reference update, then compare
  task automatic step(input logic we, input logic [2:0] a, input logic [3:0] be,
                      input logic [31:0] d, input logic dn, input logic er, input logic iq);
    logic cw, sw, nAct;
    @(negedge clk);
    wrEn = we; regAddr = a; byteEn = be; wrData = d;
    engDone = dn; engErr = er; devIrq = iq;
    cw = we && !a[2] && be[0];
    sw = we && !a[2] && be[2];
    nAct = mAct;
    if (cw && d[0] && !mGo) nAct = 1'b1;
    else if ((cw && !d[0]) || dn) nAct = 1'b0;
    if (er) mErr = 1'b1; else if (sw && d[17]) mErr = 1'b0;
    if (iq) mIrq = 1'b1; else if (sw && d[18]) mIrq = 1'b0;
    if (sw) mCap = {d[22], d[21]};
    if (cw) begin mGo = d[0]; mDir = d[3]; end
    mAct = nAct;
    for (int ln = 0; ln < 4; ln++)
      if (we && a[2] && be[ln]) mPtr[8*ln +: 8] = d[8*ln +: 8];
    @(posedge clk);
    #1;
    checkOutputs();
    check(a[2] ? "R10 R12 read" : "R7 R8 R9 R12 read", rdData, expWord(a[2]));
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    wrEn = 1'b0; engDone = 1'b0; engErr = 1'b0; devIrq = 1'b0; regAddr = a;
    #1;
    check(req, rdData, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 run", 32'(xferRun), 0);
    check("R1 dir", 32'(xferToMem), 0);
    check("R1 irq", 32'(irqOut), 0);
    check("R1 ok", 32'(xferOk), 0);
    rd(3'd0, 32'h0, "R1 ctl word");
    rd(3'd4, 32'h0, "R1 ptr word");

    // R10, R12 pointer lanes
    step(1, 3'd4, 4'b1111, 32'hA5A5_1234, 0, 0, 0);
    rd(3'd4, 32'hA5A5_1234, "R10 ptr");
    step(1, 3'd6, 4'b0100, 32'hFFFF_FFFF, 0, 0, 0);
    rd(3'd4, 32'hA5FF_1234, "R12 lane");
    // R2, R3 arm with direction
    step(1, 3'd0, 4'b0001, 32'h0000_0009, 0, 0, 0);
    check("R3 armed", 32'(xferRun), 1);
    check("R2 tomem", 32'(xferToMem), 1);
    rd(3'd0, 32'h0001_0009, "R2 R3 word");
    // R5 end of table
    step(0, 3'd0, 4'b0000, 32'h0, 1, 0, 0);
    rd(3'd0, 32'h0000_0009, "R5 go kept");
    // R3 no re-arm while go already set
    step(1, 3'd0, 4'b0001, 32'h0000_0009, 0, 0, 0);
    check("R3 no rearm", 32'(xferRun), 0);
    // R6, R11 interrupt
    step(0, 3'd0, 4'b0000, 32'h0, 0, 0, 1);
    check("R6 irq set", 32'(irqOut), 1);
    check("R11 ok", 32'(xferOk), 1);
    // R7, R9 clear and capability flags
    step(1, 3'd0, 4'b0100, 32'h00FF_0000, 0, 0, 0);
    rd(3'd0, 32'h0060_0009, "R9 cap bits");
    check("R7 irq cleared", 32'(irqOut), 0);
    // R7 set beats clear
    step(1, 3'd0, 4'b0100, 32'h0062_0000, 0, 1, 0);
    rd(3'd0, 32'h0062_0009, "R7 set wins");
    // R4 stop
    step(1, 3'd0, 4'b0001, 32'h0, 0, 0, 0);
    step(1, 3'd0, 4'b0001, 32'h1, 0, 0, 0);
    rd(3'd0, 32'h0063_0001, "R3 rearm");
    step(1, 3'd0, 4'b0001, 32'h0, 0, 0, 0);
    check("R4 stopped", 32'(xferRun), 0);
    // R8 active bit not writable
    step(1, 3'd0, 4'b0100, 32'h0067_0000, 0, 0, 0);
    rd(3'd0, 32'h0060_0000, "R8 ro active");
    // R5 re-arm beats end of table
    step(1, 3'd0, 4'b0001, 32'h1, 1, 0, 0);
    check("R5 arm wins", 32'(xferRun), 1);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic        we;
      logic [2:0]  a;
      logic [3:0]  be;
      logic [31:0] d;
      we = ($urandom % 2) == 0;
      a  = 3'(($urandom % 4) * 2);
      be = 4'($urandom);
      d  = $urandom;
      step(we, a, be, d, ($urandom % 8) == 0, ($urandom % 16) == 0, ($urandom % 8) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule